// File: doc/BRIEF.md
# Dual-Clock Packet FIFO with Commit and Discard

This block is a first-in first-out buffer whose write side and read side run on unrelated clocks. Words are pushed one at a time as the body of a packet. When the writer learns, at the end of the packet, whether its integrity check passed, it either commits the packet, which makes every word since the previous commit or discard visible to the reader, or discards it. A discard rewinds the write position so the rejected words are never seen on the read side.

The write side holds two positions: a tentative one that advances with every accepted word, and a committed one that only a commit moves. The committed position is handed to the read clock domain as a Gray code through a flop synchronizer. It moves toward the committed value one word per write-clock cycle, so the code changes by at most one bit per edge even when a whole packet is committed at once. The reader sees first-word-fall-through data with an empty flag and pops with a read enable. The full flag is computed from the tentative position, so an open packet can never overwrite unread words.

Top module: `pktfifo_dc`

## Requirements
- R1: After reset of both domains, `rdEmpty` is 1 and `wrFull` is 0.
- R2: Words accepted but not yet committed never reach the reader: `rdEmpty` stays 1 while only uncommitted words are stored.
- R3: A commit pulse makes all words accepted since the last commit or discard readable. A word written in the same cycle as the commit belongs to the committed packet.
- R4: A discard pulse drops every word accepted since the last commit and restores the write position in one write-clock cycle. A word written in the same cycle as a discard is dropped too, and a discard overrides a commit in the same cycle.
- R5: `wrFull` is 1 when the tentative write position, uncommitted words included, is DEPTH words ahead of the synchronized read position. A write while full is ignored and the write position does not move.
- R6: `rdData` shows the oldest readable word whenever `rdEmpty` is 0, and a high `rdEn` pops it. A read while empty is ignored and the read position does not move.
- R7: The committed position is published to the read domain at most one word per write-clock cycle, so the crossing Gray code changes by at most one bit per edge. A committed packet of DEPTH words is fully readable within DEPTH+4 write-clock cycles followed by 4 read-clock cycles.
- R8: Across packets of every length from 1 to DEPTH, with kept and dropped packets mixed, the reader receives exactly the kept words in the order they were written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wrClk | input | 1 | Write-domain clock |
| wrRstN | input | 1 | Write-domain asynchronous reset, active low |
| wrEn | input | 1 | Push `wrData` as the next word of the open packet |
| wrData | input | DATA_W | Word to push |
| wrCommit | input | 1 | Make the open packet readable |
| wrDiscard | input | 1 | Drop the open packet |
| wrFull | output | 1 | No room for another word |
| rdClk | input | 1 | Read-domain clock |
| rdRstN | input | 1 | Read-domain asynchronous reset, active low |
| rdEn | input | 1 | Pop the word shown on `rdData` |
| rdData | output | DATA_W | Oldest readable word |
| rdEmpty | output | 1 | No readable word |

## Verification
The write that closes a packet and its commit or discard can fall in the same write-clock cycle, and so can a discard and a commit. The bench provokes these cases by raising the end-of-packet strobe together with the last word for every packet length from one to the full depth, and by raising discard together with both a write and a commit. It judges them by draining the reader and comparing the words against a bench model, in which a word is kept with a coincident commit and dropped with a coincident discard.

// File: rtl/pktfifo_pkg.sv
package pktfifo_pkg;
  // Qualified write-side strobes for one write-clock cycle
  typedef struct packed {
    logic push;   // word accepted into storage
    logic keep;   // open packet becomes committed
    logic drop;   // open packet is rewound
  } wrCmd_t;
endpackage

// File: rtl/pktfifo_sync.sv
module pktfifo_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] chain [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[g] <= '0;
          else       chain[g] <= din;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) chain[g] <= '0;
          else       chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/pktfifo_store.sv
module pktfifo_store #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 3
) (
  input  logic              wrClk,
  input  logic              push,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge wrClk) begin
    if (push) mem[wrAddr] <= wrData;
  end

  assign rdData = mem[rdAddr];
endmodule

// File: rtl/pktfifo_wrctl.sv
module pktfifo_wrctl
  import pktfifo_pkg::*;
#(
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              wrClk,
  input  logic              wrRstN,
  input  logic              wrEn,
  input  logic              wrCommit,
  input  logic              wrDiscard,
  input  logic [ADDR_W:0]   rdGray,
  output logic              push,
  output logic [ADDR_W-1:0] wrAddr,
  output logic              wrFull,
  output logic [ADDR_W:0]   pubGray
);
  localparam int PTR_W = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [PTR_W-1:0] FULL_GAP = PTR_W'(DEPTH);

  function automatic logic [PTR_W-1:0] toGray(input logic [PTR_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PTR_W-1:0] fromGray(input logic [PTR_W-1:0] gr);
    logic [PTR_W-1:0] r;
    r[PTR_W-1] = gr[PTR_W-1];
    for (int i = PTR_W - 2; i >= 0; i--) r[i] = r[i+1] ^ gr[i];
    return r;
  endfunction

  logic [PTR_W-1:0] tentPtr, cmtPtr, pubPtr;
  logic [PTR_W-1:0] tentNext, cmtNext, pubNext;
  logic [PTR_W-1:0] rdGraySync, rdBinSync;
  wrCmd_t           cmd;

  pktfifo_sync #(.WIDTH(PTR_W), .STAGES(SYNC_STAGES)) u_rdSync (
    .clk (wrClk),
    .rstN(wrRstN),
    .din (rdGray),
    .dout(rdGraySync)
  );

  assign rdBinSync = fromGray(rdGraySync);
  assign wrFull    = (tentPtr - rdBinSync) == FULL_GAP;

  always_comb begin
    cmd.drop = wrDiscard;
    cmd.push = wrEn && !wrFull && !wrDiscard;
    cmd.keep = wrCommit && !wrDiscard;
  end

  always_comb begin
    tentNext = cmd.drop ? cmtPtr : tentPtr + PTR_W'(cmd.push);
    cmtNext  = cmd.keep ? tentPtr + PTR_W'(cmd.push) : cmtPtr;
    pubNext  = (pubPtr != cmtPtr) ? pubPtr + PTR_W'(1) : pubPtr;
  end

  always_ff @(posedge wrClk or negedge wrRstN) begin
    if (!wrRstN) begin
      tentPtr <= '0;
      cmtPtr  <= '0;
      pubPtr  <= '0;
      pubGray <= '0;
    end else begin
      tentPtr <= tentNext;
      cmtPtr  <= cmtNext;
      pubPtr  <= pubNext;
      pubGray <= toGray(pubNext);
    end
  end

  assign push   = cmd.push;
  assign wrAddr = tentPtr[ADDR_W-1:0];

  AST_DISCARD_REWIND: assert property (@(posedge wrClk) disable iff (!wrRstN)
    wrDiscard |=> tentPtr == $past(cmtPtr)); // R4
  AST_FULL_HOLDS_PTR: assert property (@(posedge wrClk) disable iff (!wrRstN)
    (wrFull && !wrDiscard) |=> $stable(tentPtr)); // R5
  AST_OPEN_SPAN: assert property (@(posedge wrClk) disable iff (!wrRstN)
    (tentPtr - cmtPtr) <= FULL_GAP); // R2
  AST_PUB_ONESTEP: assert property (@(posedge wrClk) disable iff (!wrRstN)
    $countones(pubGray ^ $past(pubGray)) <= 1); // R7
  AST_PUB_BEHIND: assert property (@(posedge wrClk) disable iff (!wrRstN)
    (cmtPtr - pubPtr) <= FULL_GAP); // R3
endmodule

// File: rtl/pktfifo_rdctl.sv
module pktfifo_rdctl #(
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              rdClk,
  input  logic              rdRstN,
  input  logic              rdEn,
  input  logic [ADDR_W:0]   pubGray,
  output logic [ADDR_W-1:0] rdAddr,
  output logic              rdEmpty,
  output logic [ADDR_W:0]   rdGray
);
  localparam int PTR_W = ADDR_W + 1;
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [PTR_W-1:0] MAX_GAP = PTR_W'(DEPTH);

  function automatic logic [PTR_W-1:0] toGray(input logic [PTR_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PTR_W-1:0] fromGray(input logic [PTR_W-1:0] gr);
    logic [PTR_W-1:0] r;
    r[PTR_W-1] = gr[PTR_W-1];
    for (int i = PTR_W - 2; i >= 0; i--) r[i] = r[i+1] ^ gr[i];
    return r;
  endfunction

  logic [PTR_W-1:0] rdPtr, rdNext, wrGraySync, wrBinSync;
  logic             pop;

  pktfifo_sync #(.WIDTH(PTR_W), .STAGES(SYNC_STAGES)) u_wrSync (
    .clk (rdClk),
    .rstN(rdRstN),
    .din (pubGray),
    .dout(wrGraySync)
  );

  assign wrBinSync = fromGray(wrGraySync);
  assign rdEmpty   = rdPtr == wrBinSync;
  assign pop       = rdEn && !rdEmpty;
  assign rdNext    = rdPtr + PTR_W'(pop);

  always_ff @(posedge rdClk or negedge rdRstN) begin
    if (!rdRstN) begin
      rdPtr  <= '0;
      rdGray <= '0;
    end else begin
      rdPtr  <= rdNext;
      rdGray <= toGray(rdNext);
    end
  end

  assign rdAddr = rdPtr[ADDR_W-1:0];

  AST_EMPTY_HOLDS_PTR: assert property (@(posedge rdClk) disable iff (!rdRstN)
    rdEmpty |=> $stable(rdPtr)); // R6
  AST_NO_OVERREAD: assert property (@(posedge rdClk) disable iff (!rdRstN)
    (wrBinSync - rdPtr) <= MAX_GAP); // R8
  AST_RD_ONESTEP: assert property (@(posedge rdClk) disable iff (!rdRstN)
    $countones(rdGray ^ $past(rdGray)) <= 1); // R7
endmodule

// File: rtl/pktfifo_dc.sv
module pktfifo_dc #(
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic              wrClk,
  input  logic              wrRstN,
  input  logic              wrEn,
  input  logic [DATA_W-1:0] wrData,
  input  logic              wrCommit,
  input  logic              wrDiscard,
  output logic              wrFull,
  input  logic              rdClk,
  input  logic              rdRstN,
  input  logic              rdEn,
  output logic [DATA_W-1:0] rdData,
  output logic              rdEmpty
);
  logic [ADDR_W:0]   pubGray, rdGray;
  logic [ADDR_W-1:0] wrAddr, rdAddr;
  logic              push;

  pktfifo_wrctl #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) u_wrctl (
    .wrClk    (wrClk),
    .wrRstN   (wrRstN),
    .wrEn     (wrEn),
    .wrCommit (wrCommit),
    .wrDiscard(wrDiscard),
    .rdGray   (rdGray),
    .push     (push),
    .wrAddr   (wrAddr),
    .wrFull   (wrFull),
    .pubGray  (pubGray)
  );

  pktfifo_store #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_store (
    .wrClk (wrClk),
    .push  (push),
    .wrAddr(wrAddr),
    .wrData(wrData),
    .rdAddr(rdAddr),
    .rdData(rdData)
  );

  pktfifo_rdctl #(.ADDR_W(ADDR_W), .SYNC_STAGES(SYNC_STAGES)) u_rdctl (
    .rdClk  (rdClk),
    .rdRstN (rdRstN),
    .rdEn   (rdEn),
    .pubGray(pubGray),
    .rdAddr (rdAddr),
    .rdEmpty(rdEmpty),
    .rdGray (rdGray)
  );
endmodule

// File: tb/test_pktfifo_dc.sv
`timescale 1ns/1ps
module test_pktfifo_dc;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 3;
  localparam int DEPTH  = 1 << ADDR_W;

  logic wrClk = 0, rdClk = 0;
  logic wrRstN = 0, rdRstN = 0;
  logic wrEn = 0, wrCommit = 0, wrDiscard = 0, rdEn = 0;
  logic [DATA_W-1:0] wrData = '0;
  logic [DATA_W-1:0] rdData;
  logic wrFull, rdEmpty;

  always #2.5 wrClk = ~wrClk;
  always #3.5 rdClk = ~rdClk;

  pktfifo_dc #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .SYNC_STAGES(2)) i_pktfifo_dc (
    .wrClk(wrClk), .wrRstN(wrRstN), .wrEn(wrEn), .wrData(wrData),
    .wrCommit(wrCommit), .wrDiscard(wrDiscard), .wrFull(wrFull),
    .rdClk(rdClk), .rdRstN(rdRstN), .rdEn(rdEn), .rdData(rdData), .rdEmpty(rdEmpty)
  );

  int runCnt = 0, failCnt = 0;
  logic [DATA_W-1:0] expQ[$];
  logic [DATA_W-1:0] pendQ[$];
  logic [DATA_W-1:0] seq = 8'h10;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    runCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Model: a word joins the open packet unless a discard coincides;
  // a commit moves the open packet into the expected read queue.
  task automatic strobe(input bit doWrite, input bit cmt, input bit drp);
    @(negedge wrClk);
    wrEn = doWrite; wrData = seq; wrCommit = cmt; wrDiscard = drp;
    if (drp) pendQ.delete();
    else begin
      if (doWrite) pendQ.push_back(seq);
      if (cmt) begin
        foreach (pendQ[i]) expQ.push_back(pendQ[i]);
        pendQ.delete();
      end
    end
    if (doWrite) seq++;
    @(negedge wrClk);
    wrEn = 0; wrCommit = 0; wrDiscard = 0;
  endtask

  task automatic settle();
    repeat (20) @(negedge wrClk);
  endtask

  task automatic drain(input string req, output int got);
    got = 0;
    forever begin
      @(negedge rdClk);
      rdEn = 0;
      if (rdEmpty) break;
      if (expQ.size() == 0) begin
        check(0, req, int'(rdData), -1);
        rdEn = 1;
      end else begin
        logic [DATA_W-1:0] e;
        e = expQ.pop_front();
        check(rdData == e, req, int'(rdData), int'(e));
        rdEn = 1;
      end
      got++;
    end
    check(expQ.size() == 0, req, expQ.size(), 0);
    expQ.delete();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge wrClk);
    failCnt++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", runCnt, 0);
    $display("  [TB] %0d tests run, %0d failed", runCnt, failCnt);
    $finish;
  end

  initial begin : stim
    int got;
    repeat (5) @(negedge wrClk);
    wrRstN = 1; rdRstN = 1;
    repeat (4) @(negedge wrClk);

    // R1 reset state
    check(rdEmpty == 1, "R1 rdEmpty", rdEmpty, 1);
    check(wrFull == 0, "R1 wrFull", wrFull, 0);

    // R2 uncommitted words stay invisible
    for (int i = 0; i < 3; i++) strobe(1, 0, 0);
    settle();
    check(rdEmpty == 1, "R2 open packet hidden", rdEmpty, 1);

    // R3 commit pulse releases them
    strobe(0, 1, 0);
    settle();
    drain("R3 commit pulse", got);
    check(got == 3, "R3 word count", got, 3);

    // R4 discard pulse, then R3 commit together with the last write
    for (int i = 0; i < 4; i++) strobe(1, 0, 0);
    strobe(0, 0, 1);
    strobe(1, 0, 0);
    strobe(1, 1, 0);
    settle();
    drain("R4 discard then keep", got);
    check(got == 2, "R3 commit with last write", got, 2);

    // R4 discard with write and commit in the same cycle drops everything
    strobe(1, 0, 0);
    strobe(1, 1, 1);
    strobe(1, 1, 0);
    settle();
    drain("R4 discard overrides", got);
    check(got == 1, "R4 only later packet kept", got, 1);

    // R5 full counts uncommitted words; extra write ignored
    for (int i = 0; i < DEPTH; i++) strobe(1, 0, 0);
    check(wrFull == 1, "R5 full from open packet", wrFull, 1);
    check(rdEmpty == 1, "R2 full open packet hidden", rdEmpty, 1);
    @(negedge wrClk); wrEn = 1; wrData = 8'hEE;
    @(negedge wrClk); wrEn = 0;
    check(wrFull == 1, "R5 still full", wrFull, 1);
    strobe(0, 1, 0);
    // R7 full packet readable within the stated window
    repeat (DEPTH + 4) @(negedge wrClk);
    repeat (4) @(negedge rdClk);
    drain("R5 write while full ignored", got);
    check(got == DEPTH, "R7 whole packet readable", got, DEPTH);
    settle();
    check(wrFull == 0, "R5 full clears after drain", wrFull, 0);

    // R6 reads while empty ignored
    for (int i = 0; i < 5; i++) begin
      @(negedge rdClk); rdEn = 1;
    end
    @(negedge rdClk); rdEn = 0;
    check(rdEmpty == 1, "R6 stays empty", rdEmpty, 1);
    strobe(1, 1, 0);
    settle();
    drain("R6 no pointer slip", got);
    check(got == 1, "R6 single word", got, 1);

    // R8 sweep: every length, commit pulse / commit with last / discard
    for (int len = 1; len <= DEPTH; len++) begin
      for (int mode = 0; mode < 3; mode++) begin
        for (int k = 0; k < len; k++)
          strobe(1, (mode == 1) && (k == len - 1), 0);
        if (mode == 0) strobe(0, 1, 0);
        if (mode == 2) strobe(0, 0, 1);
        settle();
        drain("R8 sweep order", got);
        check(got == ((mode == 2) ? 0 : len), "R8 sweep count", got, (mode == 2) ? 0 : len);
      end
    end

    // R8 several packets queued before reading
    strobe(1, 0, 0); strobe(1, 1, 0);
    strobe(1, 0, 0); strobe(0, 0, 1);
    strobe(1, 0, 0); strobe(1, 0, 0); strobe(1, 1, 0);
    settle();
    drain("R8 mixed packets", got);
    check(got == 5, "R8 mixed count", got, 5);

    $display("  [TB] %0d tests run, %0d failed", runCnt, failCnt);
    $finish;
  end
endmodule